// File: doc/BRIEF.md
# Byte ALU with status flags

This block is the execute stage for three two-register byte instructions: add, add with the incoming carry, and bitwise AND. It takes a 16-bit instruction word with a valid strobe, decodes the two 5-bit register indices straight from it so that a 32-entry register file can return both operand bytes in the same cycle, and works out the byte result together with the half-carry, sign, overflow, negative, zero and carry flags.

On the clock edge that ends an accepted instruction, the block registers three things: the result, the destination index and a one-cycle write enable for the register file. On that same edge it updates the status register it holds. Add with carry reads its carry input from that register. AND leaves the carry and half-carry flags as they were. Any opcode other than these three is treated as a no-op.

Top module: `byte_alu_flags`

## Requirements
- R1: The decoder accepts three opcodes on bits 15..10 of the instruction. 000011 is add, 000111 is add with carry and 001000 is AND. Any other value, or a cycle with valid_i low, causes no register write and leaves sreg_o unchanged.
- R2: rd_idx_o is {instr_i[8], instr_i[7:4]} and rr_idx_o is {instr_i[9], instr_i[3:0]}. Both are combinational and cover registers 0 to 31.
- R3: Add produces (rd + rr) mod 256.
- R4: Add with carry produces (rd + rr + C) mod 256, where C is sreg_o bit 0 before the instruction.
- R5: AND produces rd & rr.
- R6: For both additions, H (sreg_o bit 5) is the carry out of bit 3.
- R7: For both additions, C (sreg_o bit 0) is the carry out of bit 7.
- R8: For both additions, V (sreg_o bit 3) is set when the operands share a sign and the result's sign differs from it. AND clears V.
- R9: After every accepted instruction, N (bit 2) equals result bit 7, Z (bit 1) is set exactly when the result is 0x00, and S (bit 4) is N XOR V.
- R10: AND keeps H and C at their previous values.
- R11: sreg_o resets to 0x00 on the asynchronous active-low reset. Bits 7 and 6 are never changed by any instruction.
- R12: result_o, dst_idx_o, wr_en_o and sreg_o change on the first rising clock edge after an accepted instruction is presented. wr_en_o is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 16 | Instruction word |
| rd_data_i | input | 8 | Destination register contents (first operand) |
| rr_data_i | input | 8 | Source register contents (second operand) |
| rd_idx_o | output | 5 | Destination register read index |
| rr_idx_o | output | 5 | Source register read index |
| result_o | output | 8 | Registered result byte |
| dst_idx_o | output | 5 | Registered destination index for the write |
| wr_en_o | output | 1 | Registered one-cycle register write enable |
| sreg_o | output | 8 | Status register {I,T,H,S,V,N,Z,C} |

## Verification
The read indices are combinational, so the bench checks them 1 ns after it drives the instruction, while still in the same cycle. Result, destination, write enable and status all become due one rising edge after the instruction is driven. The driver places each instruction on a falling edge and pushes the expected item into the scoreboard queue. The monitor pops that item 1 ns after the following rising edge, so each item lines up with exactly one register stage, and the bench's own status model feeds the next add-with-carry its carry.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned SREG_W  = 8;
  localparam int unsigned OPC_W   = 6;

  localparam logic [OPC_W-1:0] OPC_ADD = 6'b000011;
  localparam logic [OPC_W-1:0] OPC_ADC = 6'b000111;
  localparam logic [OPC_W-1:0] OPC_AND = 6'b001000;

  // status bit positions; a consumer decodes these
  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_Z = 1;
  localparam int unsigned FLG_N = 2;
  localparam int unsigned FLG_V = 3;
  localparam int unsigned FLG_S = 4;
  localparam int unsigned FLG_H = 5;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_ADC  = 2'd2,
    OP_AND  = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/byte_alu_decode.sv
module byte_alu_decode
  import byte_alu_pkg::*;
#(
  parameter int unsigned IW = INSTR_W,
  parameter int unsigned XW = IDX_W
) (
  input  logic          valid_i,
  input  logic [IW-1:0] instr_i,
  output alu_op_e       op_o,
  output logic [XW-1:0] dst_idx_o,
  output logic [XW-1:0] src_idx_o
);
  localparam int unsigned LOW_W = XW - 1;
  localparam int unsigned OPC_LSB = IW - OPC_W;

  logic [OPC_W-1:0] opc;
  assign opc = instr_i[IW-1:OPC_LSB];

  // high index bits sit just under the opcode: bit 9 source, bit 8 destination
  assign src_idx_o = {instr_i[OPC_LSB-1], instr_i[LOW_W-1:0]};
  assign dst_idx_o = {instr_i[OPC_LSB-2], instr_i[2*LOW_W-1:LOW_W]};

  always_comb begin
    op_o = OP_NONE;
    if (valid_i) begin
      unique case (opc)
        OPC_ADD: op_o = OP_ADD;
        OPC_ADC: op_o = OP_ADC;
        OPC_AND: op_o = OP_AND;
        default: op_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/byte_alu_datapath.sv
module byte_alu_datapath
  import byte_alu_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          c_prev_i,
  input  logic          h_prev_i,
  output logic [DW-1:0] res_o,
  output alu_flags_t    flags_o
);
  localparam int unsigned MSB = DW - 1;
  localparam int unsigned HB  = DW / 2 - 1;

  logic          cin;
  logic [DW:0]   sum;
  logic [DW-1:0] r;
  logic          h_add, c_add, v_add;

  assign cin = (op_i == OP_ADC) ? c_prev_i : 1'b0;
  assign sum = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin};
  assign r   = (op_i == OP_AND) ? (a_i & b_i) : sum[DW-1:0];

  // carries and overflow recovered from operand and result bits
  assign h_add = (a_i[HB] & b_i[HB]) | (b_i[HB] & ~r[HB]) | (~r[HB] & a_i[HB]);
  assign c_add = (a_i[MSB] & b_i[MSB]) | (b_i[MSB] & ~r[MSB]) | (~r[MSB] & a_i[MSB]);
  assign v_add = (a_i[MSB] & b_i[MSB] & ~r[MSB]) | (~a_i[MSB] & ~b_i[MSB] & r[MSB]);

  always_comb begin
    res_o     = r;
    flags_o.n = r[MSB];
    flags_o.z = ~|r;
    if (op_i == OP_AND) begin
      flags_o.h = h_prev_i;
      flags_o.c = c_prev_i;
      flags_o.v = 1'b0;
    end else begin
      flags_o.h = h_add;
      flags_o.c = c_add;
      flags_o.v = v_add;
    end
    flags_o.s = flags_o.n ^ flags_o.v;
  end
endmodule

// File: rtl/byte_alu_sreg.sv
module byte_alu_sreg
  import byte_alu_pkg::*;
#(
  parameter int unsigned SW = SREG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  alu_flags_t    flags_i,
  output logic [SW-1:0] sreg_o
);
  logic [SW-1:0] sreg_q, sreg_d;

  always_comb begin
    sreg_d = sreg_q;
    if (upd_i) begin
      sreg_d[FLG_C] = flags_i.c;
      sreg_d[FLG_Z] = flags_i.z;
      sreg_d[FLG_N] = flags_i.n;
      sreg_d[FLG_V] = flags_i.v;
      sreg_d[FLG_S] = flags_i.s;
      sreg_d[FLG_H] = flags_i.h;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sreg_q <= '0;
    else         sreg_q <= sreg_d;
  end

  assign sreg_o = sreg_q;
endmodule

// File: rtl/byte_alu_flags.sv
module byte_alu_flags
  import byte_alu_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned XW = IDX_W,
  parameter int unsigned IW = INSTR_W,
  parameter int unsigned SW = SREG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [IW-1:0] instr_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic [DW-1:0] rr_data_i,
  output logic [XW-1:0] rd_idx_o,
  output logic [XW-1:0] rr_idx_o,
  output logic [DW-1:0] result_o,
  output logic [XW-1:0] dst_idx_o,
  output logic          wr_en_o,
  output logic [SW-1:0] sreg_o
);
  alu_op_e       op;
  logic [DW-1:0] res;
  alu_flags_t    flags;
  logic          exec;
  logic [DW-1:0] result_q;
  logic [XW-1:0] dst_q;
  logic          wr_q;

  byte_alu_decode #(.IW(IW), .XW(XW)) u_dec (
    .valid_i   (valid_i),
    .instr_i   (instr_i),
    .op_o      (op),
    .dst_idx_o (rd_idx_o),
    .src_idx_o (rr_idx_o)
  );

  byte_alu_datapath #(.DW(DW)) u_dp (
    .op_i     (op),
    .a_i      (rd_data_i),
    .b_i      (rr_data_i),
    .c_prev_i (sreg_o[FLG_C]),
    .h_prev_i (sreg_o[FLG_H]),
    .res_o    (res),
    .flags_o  (flags)
  );

  assign exec = (op != OP_NONE);

  byte_alu_sreg #(.SW(SW)) u_sreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (exec),
    .flags_i (flags),
    .sreg_o  (sreg_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      dst_q    <= '0;
      wr_q     <= 1'b0;
    end else begin
      wr_q <= exec;
      if (exec) begin
        result_q <= res;
        dst_q    <= rd_idx_o;
      end
    end
  end

  assign result_o  = result_q;
  assign dst_idx_o = dst_q;
  assign wr_en_o   = wr_q;
endmodule

// File: rtl/byte_alu_flags_chk.sv
module byte_alu_flags_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [15:0] instr_i,
  input logic [7:0]  rd_data_i,
  input logic [7:0]  rr_data_i,
  input logic [7:0]  result_o,
  input logic        wr_en_o,
  input logic [7:0]  sreg_o
);
  logic is_add, is_adc, is_and, legal;
  assign is_add = valid_i && (instr_i[15:10] == 6'b000011);
  assign is_adc = valid_i && (instr_i[15:10] == 6'b000111);
  assign is_and = valid_i && (instr_i[15:10] == 6'b001000);
  assign legal  = is_add || is_adc || is_and;

  a_r1_no_write_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal |=> (!wr_en_o && $stable(sreg_o)));

  a_r12_write_follows_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal |=> wr_en_o);

  a_r3_add_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_add |=> (result_o == 8'($past(rd_data_i) + $past(rr_data_i))));

  a_r4_adc_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_adc |=> (result_o == 8'($past(rd_data_i) + $past(rr_data_i) + {7'd0, $past(sreg_o[0])})));

  a_r5_and_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_and |=> (result_o == ($past(rd_data_i) & $past(rr_data_i))));

  a_r10_and_keeps_hc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_and |=> (sreg_o[5] == $past(sreg_o[5]) && sreg_o[0] == $past(sreg_o[0]) && !sreg_o[3]));

  a_r9_nzs_consistent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (sreg_o[2] == result_o[7] && sreg_o[1] == (result_o == 8'h00)
                 && sreg_o[4] == (sreg_o[2] ^ sreg_o[3])));

  a_r11_it_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(sreg_o[7:6]));
endmodule

bind byte_alu_flags byte_alu_flags_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .instr_i   (instr_i),
  .rd_data_i (rd_data_i),
  .rr_data_i (rr_data_i),
  .result_o  (result_o),
  .wr_en_o   (wr_en_o),
  .sreg_o    (sreg_o)
);

// File: tb/sim_byte_alu_flags.sv
module sim_byte_alu_flags;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [7:0]  rd_data_i = '0;
  logic [7:0]  rr_data_i = '0;
  logic [4:0]  rd_idx_o, rr_idx_o, dst_idx_o;
  logic [7:0]  result_o, sreg_o;
  logic        wr_en_o;

  always #5 clk_i = ~clk_i;

  byte_alu_flags u0 (
    .clk_i, .rst_ni, .valid_i, .instr_i, .rd_data_i, .rr_data_i,
    .rd_idx_o, .rr_idx_o, .result_o, .dst_idx_o, .wr_en_o, .sreg_o
  );

  typedef struct {
    logic       wr;
    logic [7:0] res;
    logic [4:0] dst;
    logic [7:0] sreg;
    string      req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  logic [7:0] m_sreg = 8'h00;
  bit done = 0;

  localparam logic [5:0] K_ADD = 6'b000011;
  localparam logic [5:0] K_ADC = 6'b000111;
  localparam logic [5:0] K_AND = 6'b001000;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(logic [5:0] opc, logic [4:0] d, logic [4:0] r);
    return {opc, r[4], d[4], d[3:0], r[3:0]};
  endfunction

  // driver: present instruction, check indices, push expectation
  task automatic issue(logic v, logic [15:0] ins, logic [7:0] a, logic [7:0] b, string req);
    exp_t e;
    logic [8:0] s9;
    logic [4:0] lo;
    logic cin;
    logic [7:0] r;
    @(negedge clk_i);
    valid_i = v; instr_i = ins; rd_data_i = a; rr_data_i = b;
    #1;
    check("R2 rd_idx", {11'd0, rd_idx_o}, {11'd0, ins[8], ins[7:4]});
    check("R2 rr_idx", {11'd0, rr_idx_o}, {11'd0, ins[9], ins[3:0]});
    e.req = req; e.wr = 1'b0; e.res = 8'h00; e.dst = 5'd0;
    if (v && (ins[15:10] == K_ADD || ins[15:10] == K_ADC || ins[15:10] == K_AND)) begin
      e.wr = 1'b1;
      e.dst = {ins[8], ins[7:4]};
      if (ins[15:10] == K_AND) begin
        r = a & b;
        m_sreg[3] = 1'b0;
      end else begin
        cin = (ins[15:10] == K_ADC) ? m_sreg[0] : 1'b0;
        s9 = {1'b0, a} + {1'b0, b} + {8'd0, cin};
        lo = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, cin};
        r = s9[7:0];
        m_sreg[0] = s9[8];
        m_sreg[5] = lo[4];
        m_sreg[3] = (a[7] == b[7]) && (r[7] != a[7]);
      end
      m_sreg[2] = r[7];
      m_sreg[1] = (r == 8'h00);
      m_sreg[4] = m_sreg[2] ^ m_sreg[3];
      e.res = r;
    end
    e.sreg = m_sreg;
    q.push_back(e);
  endtask

  // monitor: one item per rising edge
  initial forever begin
    exp_t e;
    @(posedge clk_i);
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      check({e.req, " R12 wr_en"}, {15'd0, wr_en_o}, {15'd0, e.wr});
      if (e.wr) begin
        check({e.req, " result"}, {8'd0, result_o}, {8'd0, e.res});
        check({e.req, " R12 dst"}, {11'd0, dst_idx_o}, {11'd0, e.dst});
      end
      check({e.req, " R6 H"}, {15'd0, sreg_o[5]}, {15'd0, e.sreg[5]});
      check({e.req, " R7 C"}, {15'd0, sreg_o[0]}, {15'd0, e.sreg[0]});
      check({e.req, " R8 V"}, {15'd0, sreg_o[3]}, {15'd0, e.sreg[3]});
      check({e.req, " R9 NZS"}, {13'd0, sreg_o[4], sreg_o[2:1]}, {13'd0, e.sreg[4], e.sreg[2:1]});
      check({e.req, " R11 IT"}, {14'd0, sreg_o[7:6]}, 16'd0);
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #23;
    check("R11 reset sreg", {8'd0, sreg_o}, 16'h0000);
    check("R12 reset wr_en", {15'd0, wr_en_o}, 16'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    issue(1, mk(K_ADD, 5'd1, 5'd2), 8'h0F, 8'h01, "R3 half carry");
    issue(1, mk(K_ADD, 5'd31, 5'd31), 8'h80, 8'h80, "R3 carry zero overflow");
    issue(1, mk(K_ADC, 5'd16, 5'd0), 8'h01, 8'h01, "R4 carry in");
    issue(1, mk(K_ADD, 5'd3, 5'd4), 8'h7F, 8'h01, "R3 positive overflow");
    issue(1, mk(K_ADD, 5'd5, 5'd6), 8'hFF, 8'hFF, "R7 carry set");
    issue(1, mk(K_AND, 5'd7, 5'd17), 8'hF0, 8'h8F, "R10 and keeps HC");
    issue(1, mk(K_AND, 5'd8, 5'd9), 8'h0F, 8'hF0, "R5 and zero");
    issue(1, mk(K_ADC, 5'd10, 5'd11), 8'hFF, 8'h00, "R4 adc wrap");
    issue(0, mk(K_ADD, 5'd12, 5'd13), 8'h01, 8'h02, "R1 valid low");
    issue(1, mk(6'b000010, 5'd14, 5'd15), 8'h80, 8'h80, "R1 unknown opcode");
    issue(1, mk(6'b001100, 5'd14, 5'd15), 8'hFF, 8'h01, "R1 unknown opcode");
    issue(1, mk(K_ADC, 5'd20, 5'd21), 8'h7F, 8'h00, "R4 adc overflow");
    for (int i = 0; i < 300; i++) begin
      logic [5:0] opc;
      logic [1:0] sel;
      sel = 2'($urandom_range(0, 3));
      opc = (sel == 0) ? K_ADD : (sel == 1) ? K_ADC : (sel == 2) ? K_AND : 6'($urandom);
      issue(($urandom_range(0, 7) != 0), mk(opc, 5'($urandom), 5'($urandom)),
            8'($urandom), 8'($urandom), "R9 random");
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R12 queue drained", {15'd0, q.size() != 0}, 16'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule